// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an asynchronous static RAM with a 20-bit address, an 8-bit data bus, a pair of chip selects of opposite polarity, an active-low write enable and an active-low output enable. The host offers one word at a time on a valid/ready request port carrying an address, a write flag and write data. The controller turns each accepted request into a timed pin sequence. A read result comes back with a one-clock valid strobe.

Every strobe width is a parameter counted in clock cycles, chosen so that the RAM's minimum timings hold at the host clock rate. These are the read access length, the write-enable low width, the delay before the controller drives the data bus and the idle turnaround after each access. The defaults target a 100 MHz clock. All pins are registered. The shared data bus is brought out as a separate output value, an input value and an output-enable control, so that the pad ring can build the tri-state buffer.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low, and from the first cycle of reset even in the middle of an access, the pins are idle: `ram_cs_n`=1, `ram_cs`=0, `ram_we_n`=1, `ram_oe_n`=1, `ram_dq_oe`=0. Also `rsp_valid`=0 and `req_ready`=1.
- R2: `req_ready` is high only when no access or turnaround is running. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. After that edge `req_ready` stays low for RD_CYC+TURN_CYC cycles for a read and 1+WE_CYC+TURN_CYC cycles for a write.
- R3: The chip is selected only as the pair `ram_cs_n`=0 with `ram_cs`=1, and the two selects always carry opposite levels. From the accepting edge the selection lasts exactly RD_CYC cycles for a read and 1+WE_CYC cycles for a write.
- R4: `ram_addr` takes the request address on the accepting edge and holds it without change for as long as the chip is selected.
- R5: During a read, `ram_oe_n` is low for exactly RD_CYC cycles, in step with the selection, and `ram_we_n` stays high.
- R6: A read samples `ram_dq_in` on its last selected edge. `rsp_valid` is then high for exactly one clock, and `rsp_rdata` holds the sampled byte.
- R7: During a write, `ram_we_n` falls one cycle after selection begins, stays low for exactly WE_CYC cycles and rises on the edge that ends the selection. `ram_oe_n` stays high for the whole write.
- R8: `ram_dq_oe` rises DQ_DLY_CYC cycles after `ram_we_n` falls and drops when `ram_we_n` rises, which gives WE_CYC-DQ_DLY_CYC driven cycles. While it is high, `ram_dq_out` equals the request's write data.
- R9: `ram_dq_oe` is never high while `ram_oe_n` is low, or outside the overlap of low `ram_we_n` and an active selection.
- R10: After each access the chip stays deselected for TURN_CYC cycles with `req_ready` low, before the next request can be taken.
- R11: A write never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-clock strobe: read data ready |
| rsp_rdata | output | DATA_W | Read data |
| ram_addr | output | ADDR_W | RAM address bus |
| ram_cs_n | output | 1 | Active-low chip select |
| ram_cs | output | 1 | Active-high chip select |
| ram_we_n | output | 1 | Active-low write enable |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_dq_oe | output | 1 | Drive enable for the data bus |
| ram_dq_out | output | DATA_W | Value driven onto the data bus |
| ram_dq_in | input | DATA_W | Value read from the data bus |

## Verification
The assertions take for granted that reset is applied before the first request. They also assume that the host's address and write data matter only on the accepting edge, and they make no claim about the value on `ram_dq_in`, which depends on the RAM. The stimulus presents each request for a single clock while `req_ready` is high, then overwrites the address with its complement to show that the latched value is kept. Its RAM model drives the bus only in the selected, output-enabled, non-writing state, and it stores a byte only when write enable rises at the end of a driven overlap. Read results are compared with a value computed from the address, not with the model's storage.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_WSET = 3'd2,
      ST_WLOW = 3'd3,
      ST_TURN = 3'd4
   } sram_st_e;

   function automatic int cnt_max(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
   import sram_ctrl_pkg::*;
#(
   parameter int RD_CYC   = 6,
   parameter int WE_CYC   = 5,
   parameter int TURN_CYC = 1,
   parameter int CNT_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_wr,
   output sram_st_e         st_q,
   output sram_st_e         st_nxt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             capture
);

   localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_CYC - 1);
   localparam logic [CNT_W-1:0] TN_LAST = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);

   logic [CNT_W-1:0] cnt_q;
   sram_st_e         exit_st;

   generate
      if (TURN_CYC > 0) begin : g_turn
         assign exit_st = ST_TURN;
      end else begin : g_noturn
         assign exit_st = ST_IDLE;
      end
   endgenerate

   always_comb begin
      st_nxt  = st_q;
      cnt_nxt = cnt_q + 1'b1;
      capture = 1'b0;
      case (st_q)
         ST_IDLE: begin
            cnt_nxt = '0;
            if (start) st_nxt = start_wr ? ST_WSET : ST_RD;
         end
         ST_RD: begin
            if (cnt_q == RD_LAST) begin
               st_nxt  = exit_st;
               cnt_nxt = '0;
               capture = 1'b1;
            end
         end
         ST_WSET: begin
            st_nxt  = ST_WLOW;
            cnt_nxt = '0;
         end
         ST_WLOW: begin
            if (cnt_q == WE_LAST) begin
               st_nxt  = exit_st;
               cnt_nxt = '0;
            end
         end
         ST_TURN: begin
            if (cnt_q == TN_LAST) begin
               st_nxt  = ST_IDLE;
               cnt_nxt = '0;
            end
         end
         default: begin
            st_nxt  = ST_IDLE;
            cnt_nxt = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_nxt;
         cnt_q <= cnt_nxt;
      end
   end

   // R2: a new access only starts from idle
   assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && st_q != ST_TURN) |=> (st_q != ST_IDLE || $past(capture) || $past(st_q) == ST_WLOW));

endmodule

// File: rtl/sram_pins.sv
module sram_pins
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 8,
   parameter int DQ_DLY_CYC = 1,
   parameter int CNT_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   input  sram_st_e          st_nxt,
   input  logic [CNT_W-1:0]  cnt_nxt,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_cs_n,
   output logic              ram_cs,
   output logic              ram_we_n,
   output logic              ram_oe_n,
   output logic              ram_dq_oe,
   output logic [DATA_W-1:0] ram_dq_out
);

   localparam logic [CNT_W-1:0] DRV_AT = CNT_W'(DQ_DLY_CYC);

   logic sel_d, rd_d, wr_d, drv_d;

   assign sel_d = (st_nxt == ST_RD) || (st_nxt == ST_WSET) || (st_nxt == ST_WLOW);
   assign rd_d  = (st_nxt == ST_RD);
   assign wr_d  = (st_nxt == ST_WLOW);
   assign drv_d = wr_d && (cnt_nxt >= DRV_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_cs_n   <= 1'b1;
         ram_cs     <= 1'b0;
         ram_we_n   <= 1'b1;
         ram_oe_n   <= 1'b1;
         ram_dq_oe  <= 1'b0;
         ram_addr   <= '0;
         ram_dq_out <= '0;
      end else begin
         ram_cs_n  <= ~sel_d;
         ram_cs    <= sel_d;
         ram_we_n  <= ~wr_d;
         ram_oe_n  <= ~rd_d;
         ram_dq_oe <= drv_d;
         if (accept) begin
            ram_addr   <= acc_addr;
            ram_dq_out <= acc_wdata;
         end
      end
   end

   // R3: the two selects never disagree
   assert_sel_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ram_cs_n == ~ram_cs);

   // R4: address frozen while the chip stays selected
   assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));

   // R7: write enable falls only after selection was already in place
   assert_we_after_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_we_n) |-> $past(!ram_cs_n));

   // R7: output enable never active during a write
   assert_no_oe_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> ram_oe_n);

   // R8: drive starts strictly after write enable fell
   assert_drive_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_dq_oe) |-> $past(!ram_we_n));

   // R9: no bus fight and no drive outside the write overlap
   assert_no_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ram_dq_oe |-> (ram_oe_n && !ram_we_n && !ram_cs_n && ram_cs));

endmodule

// File: rtl/sram_rdcap.sv
module sram_rdcap #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= dq_in;
      end
   end

   // R6: result held until the next capture
   assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(capture) |-> $stable(rsp_rdata));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 8,
   parameter int RD_CYC     = 6,
   parameter int WE_CYC     = 5,
   parameter int DQ_DLY_CYC = 1,
   parameter int TURN_CYC   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_cs_n,
   output logic              ram_cs,
   output logic              ram_we_n,
   output logic              ram_oe_n,
   output logic              ram_dq_oe,
   output logic [DATA_W-1:0] ram_dq_out,
   input  logic [DATA_W-1:0] ram_dq_in
);

   localparam int MAX_CNT = cnt_max(RD_CYC, WE_CYC, TURN_CYC);
   localparam int CNT_W   = $clog2(MAX_CNT + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_async_ctrl: bus widths must be positive");
      end
      if (RD_CYC < 2) begin : g_bad_rd
         $error("sram_async_ctrl: RD_CYC must be at least 2");
      end
      if (DQ_DLY_CYC < 1) begin : g_bad_dly
         $error("sram_async_ctrl: DQ_DLY_CYC must be at least 1");
      end
      if (WE_CYC <= DQ_DLY_CYC) begin : g_bad_we
         $error("sram_async_ctrl: WE_CYC must exceed DQ_DLY_CYC");
      end
      if (TURN_CYC < 0) begin : g_bad_turn
         $error("sram_async_ctrl: TURN_CYC must not be negative");
      end
   endgenerate

   sram_st_e         st_q, st_nxt;
   logic [CNT_W-1:0] cnt_nxt;
   logic             capture, accept;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   sram_seq #(
      .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept), .start_wr(req_write),
      .st_q(st_q), .st_nxt(st_nxt), .cnt_nxt(cnt_nxt), .capture(capture)
   );

   sram_pins #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DQ_DLY_CYC(DQ_DLY_CYC), .CNT_W(CNT_W)
   ) u_pins (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .acc_addr(req_addr), .acc_wdata(req_wdata),
      .st_nxt(st_nxt), .cnt_nxt(cnt_nxt),
      .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_cs(ram_cs),
      .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
      .ram_dq_oe(ram_dq_oe), .ram_dq_out(ram_dq_out)
   );

   sram_rdcap #(
      .DATA_W(DATA_W)
   ) u_rdcap (
      .clk(clk), .rst_n(rst_n), .capture(capture), .dq_in(ram_dq_in),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   // R2: ready implies the RAM is idle
   assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe));

   // R6: read strobe lasts one clock
   assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R6, R11: a strobe only follows a read with output enable active
   assert_rsp_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(!ram_oe_n) && $past(ram_we_n)));

   // R10: no selection in the cycle right after an access ends when a turnaround is configured
   assert_turn_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (TURN_CYC > 0 && $rose(ram_cs_n)) |=> ram_cs_n);

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

   localparam int AW   = 20;
   localparam int DW   = 8;
   localparam int RD   = 6;
   localparam int WE   = 5;
   localparam int DLY  = 1;
   localparam int TURN = 1;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic          req_valid, req_write;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] ram_addr;
   logic          ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_dq_oe;
   logic [DW-1:0] ram_dq_out, ram_dq_in;

   sram_async_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WE_CYC(WE),
      .DQ_DLY_CYC(DLY), .TURN_CYC(TURN)
   ) i_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
      .ram_cs_n(ram_cs_n), .ram_cs(ram_cs), .ram_we_n(ram_we_n),
      .ram_oe_n(ram_oe_n), .ram_dq_oe(ram_dq_oe), .ram_dq_out(ram_dq_out),
      .ram_dq_in(ram_dq_in)
   );

   // RAM model: 256 bytes keyed by the low address byte
   logic [DW-1:0] mem [0:255];
   logic [DW-1:0] wbuf;
   logic [7:0]    wadr;
   logic          prev_we = 1'b1;

   assign ram_dq_in = (!ram_cs_n && ram_cs && !ram_oe_n && ram_we_n) ? mem[ram_addr[7:0]] : '0;

   always @(negedge clk) begin
      if (!ram_cs_n && ram_cs && !ram_we_n && ram_dq_oe) begin
         wbuf <= ram_dq_out;
         wadr <= ram_addr[7:0];
      end
      if (!prev_we && ram_we_n) mem[wadr] <= wbuf;
      prev_we <= ram_we_n;
   end

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 5) & 255);
   endfunction

   task automatic check_idle(input string req);
      chk(ram_cs_n == 1'b1 && ram_cs == 1'b0, req, {30'd0, ram_cs_n, ram_cs}, 2);
      chk(ram_we_n && ram_oe_n, req, {30'd0, ram_we_n, ram_oe_n}, 3);
      chk(!ram_dq_oe && !rsp_valid, req, {30'd0, ram_dq_oe, rsp_valid}, 0);
      chk(req_ready, req, int'(req_ready), 1);
   endtask

   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [DW-1:0] exp_rd);
      int sel_c = 0, we_c = 0, oe_c = 0, drv_c = 0, busy_c = 0, turn_c = 0;
      int rsp_c = 0, addr_bad = 0, pol_bad = 0, clash = 0, dat_bad = 0;
      int first_we = -1, first_drv = -1, rd_val = -1;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
      for (int k = 0; k < 40; k++) begin
         if (ram_cs_n == ram_cs) pol_bad++;
         if (!ram_cs_n && ram_cs) begin
            sel_c++;
            if (ram_addr != a) addr_bad++;
         end
         if (!ram_we_n) begin
            we_c++;
            if (first_we < 0) first_we = k;
         end
         if (!ram_oe_n) oe_c++;
         if (ram_dq_oe) begin
            drv_c++;
            if (first_drv < 0) first_drv = k;
            if (ram_dq_out != d) dat_bad++;
            if (!ram_oe_n || ram_we_n || ram_cs_n) clash++;
         end
         if (!req_ready) busy_c++;
         if (!req_ready && ram_cs_n) turn_c++;
         if (rsp_valid) begin
            rsp_c++;
            rd_val = int'(rsp_rdata);
         end
         if (req_ready) break;
         @(negedge clk);
      end
      chk(sel_c == (wr ? 1 + WE : RD), "R3 select length", sel_c, wr ? 1 + WE : RD);
      chk(pol_bad == 0, "R3 select polarity", pol_bad, 0);
      chk(addr_bad == 0, "R4 address hold", addr_bad, 0);
      chk(busy_c == (wr ? 1 + WE + TURN : RD + TURN), "R2 busy length", busy_c,
          wr ? 1 + WE + TURN : RD + TURN);
      chk(turn_c == TURN, "R10 turnaround", turn_c, TURN);
      chk(clash == 0, "R9 bus drive", clash, 0);
      if (wr) begin
         chk(we_c == WE, "R7 write enable width", we_c, WE);
         chk(first_we == 1, "R7 write enable start", first_we, 1);
         chk(oe_c == 0, "R7 output enable in write", oe_c, 0);
         chk(drv_c == WE - DLY, "R8 drive length", drv_c, WE - DLY);
         chk(first_drv - first_we == DLY, "R8 drive delay", first_drv - first_we, DLY);
         chk(dat_bad == 0, "R8 drive data", dat_bad, 0);
         chk(rsp_c == 0, "R11 no strobe on write", rsp_c, 0);
      end else begin
         chk(oe_c == RD, "R5 output enable width", oe_c, RD);
         chk(we_c == 0, "R5 write enable in read", we_c, 0);
         chk(rsp_c == 1, "R6 strobe count", rsp_c, 1);
         chk(rd_val == int'(exp_rd), "R6 read data", rd_val, int'(exp_rd));
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R2 watchdog", 0, 1);
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      rst_n = 1'b0; req_valid = 1'b1; req_write = 1'b1;
      req_addr = '1; req_wdata = 8'hA5;
      repeat (3) @(negedge clk);
      check_idle("R1 reset");
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after release");

      // sweep: fill 64 words, high bits vary with index
      for (int i = 0; i < 64; i++)
         access(1'b1, {12'(i * 3 + 1), 8'(i)}, pat(i), '0);
      for (int i = 63; i >= 0; i--)
         access(1'b0, {12'(i * 3 + 1), 8'(i)}, '0, pat(i));

      // walking upper address bits
      for (int b = 8; b < AW; b++)
         access(1'b0, (20'h1 << b) | 20'(b), '0, pat(b));

      // write then immediate read back
      for (int k = 0; k < 16; k++) begin
         access(1'b1, {12'hFFF - 12'(k), 8'(200 + k)}, 8'(k * 17), '0);
         access(1'b0, {12'h5A5, 8'(200 + k)}, '0, 8'(k * 17));
      end

      // reset in the middle of a write
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h000FA; req_wdata = 8'h3C;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_idle("R1 mid-access reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      access(1'b0, 20'h00007, '0, pat(7));

      done = 1'b1;
      finish_run();
   end

endmodule